// File: doc/BRIEF.md
# Three-Wire Sampling Converter Reader

This block is the host side of a link to a 16-bit successive-approximation converter. The link has three wires: an active-low select, a data clock, and a serial data return. While its enable input is high, the block runs conversions at a programmable rate. Each conversion starts on a select falling edge. The block then makes a burst of data clocks from the system clock through a programmable divider. It throws away the undriven start of the serial stream and the forced zero bit that comes before the result. It gathers the 16 result bits, most significant first, and releases select at the end of the burst.

Each finished word appears for one system cycle together with a valid strobe. Two status flags travel with it: one marks the all-ones code (the input may be above full scale) and one marks the all-zeros code (the input may be below ground). Settings that would break the converter's limits are clamped, not rejected. These limits are the data-clock rate, the shortest conversion cycle, and the select-high acquisition time.

Sampling of each bit is normally done on the data-clock falling edge, while the previous bit is still held. A build parameter moves sampling to the rising edge. All counts below use the default parameters and a 100 MHz system clock.

Top module: `adc3w_reader`

## Requirements
- R1: Out of reset `csN` is high, `sclk` is low and `sampleValid` is low. `sclk` stays low whenever `csN` is high.
- R2: Each high and each low phase of `sclk` lasts h system cycles, where h = max(`divCfg`, MIN_HALF). MIN_HALF defaults to 18, which keeps the data clock at or below 2.9 MHz for a 100 MHz system clock.
- R3: `sclk` is low when `csN` falls. The first `sclk` rising edge comes exactly CS_SETUP + h cycles after the `csN` fall (CS_SETUP defaults to 2, which is 20 ns).
- R4: A frame has FRAME_CYC data-clock cycles (default 24; never fewer than 22). `csN` rises in the same cycle as the last falling edge, so `csN` stays low for CS_SETUP + 2*FRAME_CYC*h cycles.
- R5: Between two consecutive `csN` falls there are exactly P cycles, where P = max(`periodCfg`, MIN_PERIOD, CS_SETUP + 2*FRAME_CYC*h + MIN_CSHIGH). MIN_PERIOD defaults to 1000 cycles (10 us).
- R6: Between frames `csN` stays high for at least MIN_CSHIGH cycles (default 40, which is 400 ns).
- R7: Count `sclk` falling edges from 1 after each `csN` fall. `sdi` is sampled at falling edges 7 through 22, and the bit sampled at edge 7 is bit 15 of `sampleData`. The level held before edge 6 (the undriven lead-in) is ignored, and so is the forced zero sampled at edge 6.
- R8: `sampleValid` is high for a single cycle. It rises CS_SETUP + 44*h + 1 cycles after the `csN` fall, one cycle after the last bit is captured, with the new word on `sampleData`.
- R9: `overRange` is high exactly when `sampleValid` is high and the word is 16'hFFFF. `underRange` is high exactly when `sampleValid` is high and the word is 16'h0000.
- R10: When `enable` rises while the block is idle and at least P cycles have passed since the last frame start, `csN` falls on the next clock edge. When `enable` falls, the frame in progress completes with its result, and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs periodic conversions while high |
| divCfg | input | 8 | Data-clock half period in system cycles (clamped up to MIN_HALF) |
| periodCfg | input | 24 | Conversion period in system cycles (clamped up to the legal minimum) |
| sdi | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low converter select; its falling edge starts a conversion |
| sclk | output | 1 | Data clock to the converter |
| sampleValid | output | 1 | One-cycle strobe marking a new word |
| sampleData | output | 16 | Conversion result, straight binary |
| overRange | output | 1 | Result is all ones, qualified by sampleValid |
| underRange | output | 1 | Result is all zeros, qualified by sampleValid |

## Verification
Every result is timed from the `csN` falling edge:
- the first data-clock rise is due CS_SETUP + h cycles later;
- each clock phase lasts h cycles;
- `csN` rises after CS_SETUP + 2*FRAME_CYC*h cycles;
- the valid strobe comes CS_SETUP + 44*h + 1 cycles after the fall;
- the next fall follows P cycles after the previous one.

The bench counts rising system-clock edges and samples all outputs on the falling edge. It compares these distances exactly, using h and P that it computes itself from the configuration in force when the frame started. The serial model in the bench changes `sdi` one nanosecond after each data-clock falling edge, so the bit the design samples at that edge is always the one driven before it.

// File: rtl/adc3w_pkg.sv
`timescale 1ns/1ps
package adc3w_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CLOCK = 2'd2
  } ctrlState_t;

  // strobes from the sequencer to the capture datapath
  typedef struct packed {
    logic clear;
    logic shift;
    logic last;
  } dpStrobe_t;

endpackage

// File: rtl/adc3w_ctrl.sv
`timescale 1ns/1ps
module adc3w_ctrl
  import adc3w_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int HALF_W      = 8,
  parameter int PER_W       = 24,
  parameter int MIN_HALF    = 18,
  parameter int MIN_PERIOD  = 1000,
  parameter int MIN_CSHIGH  = 40,
  parameter int CS_SETUP    = 2,
  parameter int FRAME_CYC   = 24,
  parameter int LEAD_FALLS  = 5,
  parameter int SAMPLE_RISE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [HALF_W-1:0] divCfg,
  input  logic [PER_W-1:0]  periodCfg,
  output logic              csN,
  output logic              sclk,
  output dpStrobe_t         strb
);

  // first captured edge follows the lead-in edges and the forced-zero edge
  localparam int FIRST_EDGE = LEAD_FALLS + 2;
  localparam int LAST_EDGE  = FIRST_EDGE + DATA_W - 1;
  localparam int FRAME_EFF  = (FRAME_CYC < LAST_EDGE) ? LAST_EDGE : FRAME_CYC;
  localparam int EDGE_W     = $clog2(FRAME_EFF + 1);
  localparam int SET_W      = (CS_SETUP > 1) ? $clog2(CS_SETUP) : 1;
  localparam int HIGH_W     = $clog2(MIN_CSHIGH + 1);
  localparam logic [HALF_W-1:0] HALF_FLOOR = HALF_W'(MIN_HALF);
  localparam logic [HIGH_W-1:0] HIGH_SAT   = HIGH_W'(MIN_CSHIGH);

  ctrlState_t        state;
  logic              csQ, sclkQ;
  logic [HALF_W-1:0] halfReq, halfLat, halfCnt;
  logic [31:0]       frameFloor, periodReq, periodLat, periodCnt;
  logic [EDGE_W-1:0] fallCnt, edgeNum;
  logic [SET_W-1:0]  setupCnt;
  logic [HIGH_W-1:0] highCnt;
  logic              csReady, periodDone, startNow, toggle, sampleEdge, inWindow;

  // clamp the requested settings to the converter limits
  always_comb begin
    halfReq    = (divCfg < HALF_FLOOR) ? HALF_FLOOR : divCfg;
    frameFloor = 32'(CS_SETUP) + 32'(MIN_CSHIGH) + 32'(2 * FRAME_EFF) * 32'(halfReq);
    periodReq  = 32'(periodCfg);
    if (periodReq < 32'(MIN_PERIOD)) periodReq = 32'(MIN_PERIOD);
    if (periodReq < frameFloor)      periodReq = frameFloor;
  end

  always_comb begin
    csReady    = (32'(highCnt) + 32'd1) >= 32'(MIN_CSHIGH);
    periodDone = periodCnt >= (periodLat - 32'd1);
    startNow   = (state == ST_WAIT) && enable && csReady && periodDone;
    toggle     = (state == ST_CLOCK) && (halfCnt == '0);
    edgeNum    = fallCnt + EDGE_W'(1);
    inWindow   = (edgeNum >= EDGE_W'(FIRST_EDGE)) && (edgeNum <= EDGE_W'(LAST_EDGE));
  end

  generate
    if (SAMPLE_RISE != 0) begin : g_rise
      assign sampleEdge = toggle && !sclkQ;
    end else begin : g_fall
      assign sampleEdge = toggle && sclkQ;
    end
  endgenerate

  always_comb begin
    strb.clear = startNow;
    strb.shift = sampleEdge && inWindow;
    strb.last  = sampleEdge && (edgeNum == EDGE_W'(LAST_EDGE));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_WAIT;
      csQ       <= 1'b1;
      sclkQ     <= 1'b0;
      halfLat   <= HALF_FLOOR;
      halfCnt   <= '0;
      periodLat <= 32'(MIN_PERIOD);
      periodCnt <= '1;
      fallCnt   <= '0;
      setupCnt  <= '0;
      highCnt   <= HIGH_SAT;
    end else begin
      if (periodCnt != '1) periodCnt <= periodCnt + 32'd1;
      if (csQ && (highCnt != HIGH_SAT)) highCnt <= highCnt + HIGH_W'(1);
      unique case (state)
        ST_WAIT: begin
          if (startNow) begin
            state     <= ST_SETUP;
            csQ       <= 1'b0;
            periodCnt <= '0;
            halfLat   <= halfReq;
            periodLat <= periodReq;
            setupCnt  <= SET_W'(CS_SETUP - 1);
            fallCnt   <= '0;
          end
        end
        ST_SETUP: begin
          if (setupCnt == '0) begin
            state   <= ST_CLOCK;
            halfCnt <= halfLat - HALF_W'(1);
          end else begin
            setupCnt <= setupCnt - SET_W'(1);
          end
        end
        ST_CLOCK: begin
          if (toggle) begin
            halfCnt <= halfLat - HALF_W'(1);
            sclkQ   <= ~sclkQ;
            if (sclkQ) begin
              fallCnt <= edgeNum;
              if (edgeNum == EDGE_W'(FRAME_EFF)) begin
                csQ     <= 1'b1;
                highCnt <= '0;
                state   <= ST_WAIT;
              end
            end
          end else begin
            halfCnt <= halfCnt - HALF_W'(1);
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  assign csN  = csQ;
  assign sclk = sclkQ;

endmodule

// File: rtl/adc3w_dp.sv
`timescale 1ns/1ps
module adc3w_dp
  import adc3w_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  dpStrobe_t         strb,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              overRange,
  output logic              underRange
);

  logic [DATA_W-1:0] shiftQ, dataQ;
  logic              pendQ, validQ, overQ, underQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      dataQ  <= '0;
      pendQ  <= 1'b0;
      validQ <= 1'b0;
      overQ  <= 1'b0;
      underQ <= 1'b0;
    end else begin
      if (strb.clear)      shiftQ <= '0;
      else if (strb.shift) shiftQ <= {shiftQ[DATA_W-2:0], sdi};
      pendQ  <= strb.last;
      validQ <= pendQ;
      overQ  <= pendQ && (&shiftQ);
      underQ <= pendQ && (shiftQ == '0);
      if (pendQ) dataQ <= shiftQ;
    end
  end

  assign sampleValid = validQ;
  assign sampleData  = dataQ;
  assign overRange   = overQ;
  assign underRange  = underQ;

endmodule

// File: rtl/adc3w_reader.sv
`timescale 1ns/1ps
module adc3w_reader
  import adc3w_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int HALF_W      = 8,
  parameter int PER_W       = 24,
  parameter int MIN_HALF    = 18,
  parameter int MIN_PERIOD  = 1000,
  parameter int MIN_CSHIGH  = 40,
  parameter int CS_SETUP    = 2,
  parameter int FRAME_CYC   = 24,
  parameter int LEAD_FALLS  = 5,
  parameter int SAMPLE_RISE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [HALF_W-1:0] divCfg,
  input  logic [PER_W-1:0]  periodCfg,
  input  logic              sdi,
  output logic              csN,
  output logic              sclk,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              overRange,
  output logic              underRange
);

  dpStrobe_t strb;

  adc3w_ctrl #(
    .DATA_W(DATA_W), .HALF_W(HALF_W), .PER_W(PER_W), .MIN_HALF(MIN_HALF),
    .MIN_PERIOD(MIN_PERIOD), .MIN_CSHIGH(MIN_CSHIGH), .CS_SETUP(CS_SETUP),
    .FRAME_CYC(FRAME_CYC), .LEAD_FALLS(LEAD_FALLS), .SAMPLE_RISE(SAMPLE_RISE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .divCfg(divCfg),
    .periodCfg(periodCfg), .csN(csN), .sclk(sclk), .strb(strb)
  );

  adc3w_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdi(sdi), .strb(strb),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .overRange(overRange), .underRange(underRange)
  );

endmodule

// File: rtl/adc3w_reader_chk.sv
`timescale 1ns/1ps
module adc3w_reader_chk #(
  parameter int DATA_W     = 16,
  parameter int MIN_HALF   = 18,
  parameter int MIN_PERIOD = 1000,
  parameter int MIN_CSHIGH = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              sclk,
  input logic              sampleValid,
  input logic [DATA_W-1:0] sampleData,
  input logic              overRange,
  input logic              underRange
);

  logic        prevCs, prevSclk, csFell, sclkMoved;
  logic [31:0] togCnt, highCnt, perCnt;

  assign csFell    = prevCs && !csN;
  assign sclkMoved = sclk != prevSclk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCs   <= 1'b1;
      prevSclk <= 1'b0;
      togCnt   <= '1;
      highCnt  <= 32'(MIN_CSHIGH);
      perCnt   <= 32'(MIN_PERIOD);
    end else begin
      prevCs   <= csN;
      prevSclk <= sclk;
      if (sclkMoved)         togCnt <= '0;
      else if (togCnt != '1) togCnt <= togCnt + 32'd1;
      if (!csN)               highCnt <= '0;
      else if (highCnt != '1) highCnt <= highCnt + 32'd1;
      if (csFell)            perCnt <= 32'd1;
      else if (perCnt != '1) perCnt <= perCnt + 32'd1;
    end
  end

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  p_half_min_r2: assert property (@(posedge clk) disable iff (!rstN)
    sclkMoved |-> (togCnt >= 32'(MIN_HALF - 1)));
  p_setup_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    csFell |=> !sclk);
  p_period_min_r5: assert property (@(posedge clk) disable iff (!rstN)
    csFell |-> (perCnt >= 32'(MIN_PERIOD)));
  p_cs_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    csFell |-> (highCnt >= 32'(MIN_CSHIGH)));
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);
  p_flags_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> ((overRange == (&sampleData)) && (underRange == (sampleData == '0))));
  p_flags_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> (!overRange && !underRange));

endmodule

bind adc3w_reader adc3w_reader_chk #(
  .DATA_W(DATA_W), .MIN_HALF(MIN_HALF), .MIN_PERIOD(MIN_PERIOD), .MIN_CSHIGH(MIN_CSHIGH)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sampleValid(sampleValid),
  .sampleData(sampleData), .overRange(overRange), .underRange(underRange)
);

// File: tb/adc3w_reader_bench.sv
`timescale 1ns/1ps
module adc3w_reader_bench;

  localparam int MIN_HALF   = 18;
  localparam int MIN_PERIOD = 1000;
  localparam int MIN_CSHIGH = 40;
  localparam int CS_SETUP   = 2;
  localparam int FRAME      = 24;
  localparam int LAST_EDGE  = 22;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  divCfg = 8'd20;
  logic [23:0] periodCfg = 24'd1500;
  logic        sdi = 1'b1;
  logic        csN, sclk, sampleValid, overRange, underRange;
  logic [15:0] sampleData;

  always #5 clk = ~clk;

  adc3w_reader u_adc3w_reader (
    .clk(clk), .rstN(rstN), .enable(enable), .divCfg(divCfg), .periodCfg(periodCfg),
    .sdi(sdi), .csN(csN), .sclk(sclk), .sampleValid(sampleValid),
    .sampleData(sampleData), .overRange(overRange), .underRange(underRange)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int expHalf(input int d);
    return (d < MIN_HALF) ? MIN_HALF : d;
  endfunction

  function automatic int expPeriod(input int d, input int p);
    int h, fl, r;
    h  = expHalf(d);
    fl = CS_SETUP + MIN_CSHIGH + 2 * FRAME * h;
    r  = p;
    if (r < MIN_PERIOD) r = MIN_PERIOD;
    if (r < fl) r = fl;
    return r;
  endfunction

  function automatic logic [15:0] pickWord(input int idx);
    case (idx)
      0: return 16'hFFFF;
      1: return 16'h0000;
      2: return 16'h8000;
      3: return 16'h0001;
      4: return 16'h7FFF;
      5: return 16'hAAAA;
      default: return 16'($urandom);
    endcase
  endfunction

  // converter model: changes its output 1 ns after each data-clock fall
  logic [15:0] modelWord = '0;
  int          wordIdx = 0;
  function automatic logic bitAfter(input int n, input logic [15:0] w);
    if (n < 5)   return 1'b1;
    if (n == 5)  return 1'b0;
    if (n <= 21) return w[21 - n];
    return 1'b0;
  endfunction

  initial begin
    forever begin
      int fcnt;
      @(negedge csN);
      fcnt      = 0;
      modelWord = pickWord(wordIdx);
      wordIdx++;
      sdi = 1'b1;
      while (!csN) begin
        @(negedge sclk or posedge csN);
        if (!csN) begin
          fcnt++;
          #1 sdi = bitAfter(fcnt, modelWord);
        end
      end
      sdi = 1'b1;
    end
  end

  // monitor, sampled on the falling system-clock edge
  logic prevCs = 1'b1, prevSclk = 1'b0, prevValid = 1'b0;
  int   frames = 0, valids = 0, rises = 0;
  int   frameStart = 0, lastFall = 0, lastRise = 0, highStart = 0;
  int   curH = MIN_HALF, curP = MIN_PERIOD;
  bit   haveFall = 0, haveHigh = 0, gapFree = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevCs && !csN) begin
        if (haveFall && gapFree)
          check(cyc - lastFall == curP, "R5 select period", cyc - lastFall, curP);
        if (haveHigh)
          check(cyc - highStart >= MIN_CSHIGH, "R6 select high time", cyc - highStart, MIN_CSHIGH);
        check(!sclk, "R3 clock low at select fall", sclk, 0);
        curH = expHalf(int'(divCfg));
        curP = expPeriod(int'(divCfg), int'(periodCfg));
        haveFall = 1; gapFree = 1;
        lastFall = cyc; frameStart = cyc; rises = 0;
        frames++;
      end
      if (!prevCs && csN) begin
        check(rises == FRAME, "R4 clock count", rises, FRAME);
        check(cyc - frameStart == CS_SETUP + 2 * FRAME * curH, "R4 select low length",
              cyc - frameStart, CS_SETUP + 2 * FRAME * curH);
        highStart = cyc; haveHigh = 1;
      end
      if (!prevSclk && sclk) begin
        rises++;
        if (rises == 1)
          check(cyc - frameStart == CS_SETUP + curH, "R3 first rise delay",
                cyc - frameStart, CS_SETUP + curH);
        else
          check(cyc - lastRise == 2 * curH, "R2 clock period", cyc - lastRise, 2 * curH);
        lastRise = cyc;
      end
      if (prevSclk && !sclk)
        check(cyc - lastRise == curH, "R2 high phase", cyc - lastRise, curH);
      if (sampleValid) begin
        valids++;
        check(sampleData == modelWord, "R7 captured word", sampleData, modelWord);
        check(cyc - frameStart == CS_SETUP + 2 * LAST_EDGE * curH + 1, "R8 valid latency",
              cyc - frameStart, CS_SETUP + 2 * LAST_EDGE * curH + 1);
        check(overRange == (sampleData == 16'hFFFF), "R9 over flag", overRange, sampleData == 16'hFFFF);
        check(underRange == (sampleData == 16'h0000), "R9 under flag", underRange, sampleData == 16'h0000);
        if (prevValid) check(0, "R8 single pulse", 1, 0);
      end else if (overRange || underRange) begin
        check(0, "R9 flag without valid", 1, 0);
      end
      if (!enable) gapFree = 0;
    end
    prevCs = csN; prevSclk = sclk; prevValid = sampleValid;
  end

  task automatic runFrames(input int d, input int p, input int n);
    int f0, t0, fIdle, vNeed;
    divCfg    = 8'(d);
    periodCfg = 24'(p);
    @(negedge clk);
    f0 = frames;
    enable = 1'b1;
    t0 = cyc;
    @(negedge clk);
    check(!csN && (cyc - t0 == 1), "R10 start on enable", cyc - t0, 1);
    while (frames < f0 + n) @(negedge clk);
    enable = 1'b0;                // drop mid-frame: this frame must still finish
    vNeed = frames;
    while (valids < vNeed) @(negedge clk);
    while (!csN) @(negedge clk);
    fIdle = frames;
    repeat (3000) @(negedge clk);
    check(frames == fIdle, "R10 no frame after disable", frames, fIdle);
    check(valids == vNeed, "R10 last frame delivered", valids, vNeed);
  endtask

  initial begin
    void'($urandom(32'd20240613));
    repeat (5) @(negedge clk);
    check(csN == 1'b1, "R1 reset select", csN, 1);
    check(sclk == 1'b0, "R1 reset clock", sclk, 0);
    check(sampleValid == 1'b0, "R1 reset valid", sampleValid, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(csN && !sclk && !sampleValid, "R1 idle after reset", csN, 1);

    runFrames(20, 1500, 6);   // directed words incl. all-ones and all-zeros
    runFrames(1, 5, 4);       // divider and period clamped to floors
    runFrames(40, 1200, 3);   // period clamped up to frame length
    runFrames(0, 0, 2);
    for (int i = 0; i < 4; i++) begin
      runFrames(int'($urandom_range(35, 10)), int'($urandom_range(2600, 900)), 3);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #1500000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog R10 progress actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule